// File: doc/BRIEF.md
# Two-Operand ALU With One Shared Complementer

This combinational unit forms the integer result of a small processor's execute stage. It offers four arithmetic operations (plain add, plain subtract, and the carry-chained forms of both) and up to eight two-input boolean functions. The second operand passes through a single conditional complementer before it reaches either the adder or the boolean unit. That one complementer serves subtraction and also the boolean forms that need an inverted operand, so the extra boolean functions cost only a few decode gates.

The caller chooses arithmetic or boolean work with `arith_en`. In arithmetic mode, `sub_en` picks subtraction and `chain_en` folds the incoming flag into the operation. In boolean mode, `logic_fn` picks the function. The parameter `FULL_ROP` picks the selector variant. With `FULL_ROP=1` all eight functions are decoded. With `FULL_ROP=0` the unit keeps only the four functions that a two-bit code can reach. The width is set by `WIDTH` and defaults to 16.

Top module: `alu_rop2`

## Requirements
- R1: With arith_en=1, sub_en=0 and chain_en=0, result equals (opnd_a + opnd_b) modulo 2^WIDTH, and flag_out is the carry out of the top bit.
- R2: With arith_en=1, sub_en=1 and chain_en=0, result equals (opnd_a - opnd_b) modulo 2^WIDTH, and flag_out is an active-high borrow that is 1 exactly when opnd_a < opnd_b as unsigned numbers.
- R3: With arith_en=1, sub_en=1 and chain_en=1, flag_in is an incoming borrow. Result equals opnd_a - opnd_b - flag_in, and flag_out is 1 exactly when opnd_a < opnd_b + flag_in.
- R4: With arith_en=1, sub_en=0 and chain_en=1, flag_in is an incoming carry. Result equals opnd_a + opnd_b + flag_in, and flag_out is the carry out.
- R5: With arith_en=0, logic_fn codes 3'b000, 3'b001, 3'b010 and 3'b011 give A AND B, A OR B, A XOR B and A AND NOT B.
- R6: With FULL_ROP=1 and arith_en=0, codes 3'b100, 3'b101, 3'b110 and 3'b111 give NOT(A AND B), NOT(A OR B), NOT(A XOR B) and A OR NOT B.
- R7: With FULL_ROP=0, logic_fn[2] has no effect, so code 1xx produces the same result as code 0xx.
- R8: With arith_en=0, flag_out is 0 and sub_en, chain_en and flag_in have no effect on result.
- R9: zero_out is 1 exactly when every bit of result is 0, in every mode.
- R10: With arith_en=1, logic_fn has no effect on result or flag_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand; passes through the shared complementer |
| arith_en | input | 1 | 1 selects arithmetic, 0 selects boolean |
| sub_en | input | 1 | In arithmetic mode, selects subtraction |
| chain_en | input | 1 | In arithmetic mode, uses flag_in as carry or borrow in |
| flag_in | input | 1 | Incoming carry (add) or borrow (subtract) |
| logic_fn | input | 3 | Boolean function code |
| result | output | WIDTH | Operation result |
| flag_out | output | 1 | Carry out on add, borrow out on subtract, 0 in boolean mode |
| zero_out | output | 1 | 1 when result is all zeros |

## Verification
The unit holds no state, so a fault in its decode shows at the ports in the same evaluation as the input that exercises it. If the complementer control is wrong, one sign of it is that the result of a subtraction differs from the operand difference by one bit pattern. Other signs are that ANDN returns plain AND, or that the borrow polarity flips on operand pairs where A < B. A wrong output-inversion decode shows up on the upper function codes as the bitwise complement of the expected value. The bench uses operand pairs chosen so that each of these slips produces a visible difference.

// File: rtl/alu_rop2_pkg.sv
package alu_rop2_pkg;

   // Boolean function codes seen on logic_fn.
   typedef enum logic [2:0] {
      FN_AND  = 3'b000,
      FN_OR   = 3'b001,
      FN_XOR  = 3'b010,
      FN_ANDN = 3'b011,
      FN_NAND = 3'b100,
      FN_NOR  = 3'b101,
      FN_XORN = 3'b110,
      FN_ORN  = 3'b111
   } rop_fn_e;

   // Primitive gate applied bitwise by the boolean unit.
   typedef enum logic [1:0] {
      GATE_AND = 2'd0,
      GATE_OR  = 2'd1,
      GATE_XOR = 2'd2
   } gate_e;

   // Decoded controls for one boolean function.
   typedef struct packed {
      logic  inv_b;
      logic  inv_out;
      gate_e gate;
   } rop_ctl_t;

   function automatic rop_ctl_t decode_rop(input logic [2:0] code);
      rop_ctl_t c;
      c.inv_b   = (code[1:0] == 2'b11);
      c.inv_out = code[2] & (code[1:0] != 2'b11);
      unique case (code[1:0])
         2'b00:   c.gate = GATE_AND;
         2'b01:   c.gate = GATE_OR;
         2'b10:   c.gate = GATE_XOR;
         default: c.gate = code[2] ? GATE_OR : GATE_AND;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/alu_operand_inv.sv
module alu_operand_inv #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] b_in,
   input  logic             inv,
   output logic [WIDTH-1:0] b_out
);
   assign b_out = b_in ^ {WIDTH{inv}};
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] bx,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int EXT = WIDTH + 1;

   logic [EXT-1:0] total;

   assign total = {1'b0, a} + {1'b0, bx} + {{WIDTH{1'b0}}, cin};
   assign sum   = total[WIDTH-1:0];
   assign cout  = total[EXT-1];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import alu_rop2_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter bit FULL_ROP = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] bx,
   input  logic [2:0]       fn,
   output logic             need_inv,
   output logic [WIDTH-1:0] y
);
   logic [2:0]       fn_eff;
   rop_ctl_t         ctl;
   logic [WIDTH-1:0] gate_y;

   generate
      if (FULL_ROP) begin : g_full
         assign fn_eff = fn;
      end else begin : g_reduced
         assign fn_eff = {1'b0, fn[1:0]};
      end
   endgenerate

   assign ctl      = decode_rop(fn_eff);
   assign need_inv = ctl.inv_b;

   always_comb begin
      unique case (ctl.gate)
         GATE_OR:  gate_y = a | bx;
         GATE_XOR: gate_y = a ^ bx;
         default:  gate_y = a & bx;
      endcase
   end

   assign y = gate_y ^ {WIDTH{ctl.inv_out}};
endmodule

// File: rtl/alu_rop2.sv
module alu_rop2
   import alu_rop2_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter bit FULL_ROP = 1'b1
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             arith_en,
   input  logic             sub_en,
   input  logic             chain_en,
   input  logic             flag_in,
   input  logic [2:0]       logic_fn,
   output logic [WIDTH-1:0] result,
   output logic             flag_out,
   output logic             zero_out
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_rop2: WIDTH must be at least 2");
      end
   endgenerate

   logic             inv_b;
   logic             logic_inv;
   logic [WIDTH-1:0] b_x;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             cin;
   logic [WIDTH-1:0] logic_y;

   // One complementer feeds both the adder and the boolean unit.
   assign inv_b = arith_en ? sub_en : logic_inv;

   alu_operand_inv #(.WIDTH(WIDTH)) u_inv (
      .b_in  (opnd_b),
      .inv   (inv_b),
      .b_out (b_x)
   );

   // Add: cin = carry.  Subtract: cin = NOT borrow (1 when unchained).
   assign cin = sub_en ^ (chain_en & flag_in);

   alu_adder #(.WIDTH(WIDTH)) u_add (
      .a    (opnd_a),
      .bx   (b_x),
      .cin  (cin),
      .sum  (sum),
      .cout (cout)
   );

   alu_logic_unit #(.WIDTH(WIDTH), .FULL_ROP(FULL_ROP)) u_logic (
      .a        (opnd_a),
      .bx       (b_x),
      .fn       (logic_fn),
      .need_inv (logic_inv),
      .y        (logic_y)
   );

   assign result   = arith_en ? sum : logic_y;
   assign flag_out = arith_en & (cout ^ sub_en);
   assign zero_out = ~|result;
endmodule

// File: rtl/alu_rop2_chk.sv
module alu_rop2_chk #(
   parameter int WIDTH    = 16,
   parameter bit FULL_ROP = 1'b1
) (
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic             arith_en,
   input logic             sub_en,
   input logic             chain_en,
   input logic             flag_in,
   input logic [2:0]       logic_fn,
   input logic [WIDTH-1:0] result,
   input logic             flag_out,
   input logic             zero_out
);
   always_comb begin
      // R8
      logic_flag_chk: assert (arith_en || !flag_out);
      // R9
      zero_flag_chk: assert (zero_out == (result == '0));
      // R1
      if (arith_en && !sub_en && !chain_en)
         add_sum_chk: assert ({flag_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}));
      // R2
      if (arith_en && sub_en && !chain_en)
         sub_borrow_chk: assert ((result == WIDTH'(opnd_a - opnd_b)) && (flag_out == (opnd_a < opnd_b)));
      // R5
      if (!arith_en && logic_fn == 3'b011)
         andn_chk: assert (result == (opnd_a & ~opnd_b));
      // R6
      if (FULL_ROP && !arith_en && logic_fn == 3'b100)
         nand_chk: assert (result == ~(opnd_a & opnd_b));
      // R3
      if (arith_en && sub_en && chain_en && flag_in && opnd_a == opnd_b)
         sbb_wrap_chk: assert (flag_out && result == '1);
   end
endmodule

bind alu_rop2 alu_rop2_chk #(.WIDTH(WIDTH), .FULL_ROP(FULL_ROP)) u_chk (
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .arith_en (arith_en),
   .sub_en   (sub_en),
   .chain_en (chain_en),
   .flag_in  (flag_in),
   .logic_fn (logic_fn),
   .result   (result),
   .flag_out (flag_out),
   .zero_out (zero_out)
);

// File: tb/alu_rop2_bench.sv
module alu_rop2_bench;
   localparam int  W      = 16;
   localparam time PERIOD = 10ns;
   localparam int  LIMIT  = 100000;

   logic         clk = 1'b0;
   logic [W-1:0] a, b;
   logic         arith, sub, chain, fin;
   logic [2:0]   fn;
   logic [W-1:0] res, res_r;
   logic         fo, fo_r, zo, zo_r;
   int           checks = 0;
   int           errors = 0;
   bit           done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   alu_rop2 #(.WIDTH(W), .FULL_ROP(1'b1)) u_alu_rop2 (
      .opnd_a(a), .opnd_b(b), .arith_en(arith), .sub_en(sub),
      .chain_en(chain), .flag_in(fin), .logic_fn(fn),
      .result(res), .flag_out(fo), .zero_out(zo)
   );

   alu_rop2 #(.WIDTH(W), .FULL_ROP(1'b0)) u_alu_rop2_red (
      .opnd_a(a), .opnd_b(b), .arith_en(arith), .sub_en(sub),
      .chain_en(chain), .flag_in(fin), .logic_fn(fn),
      .result(res_r), .flag_out(fo_r), .zero_out(zo_r)
   );

   task automatic drive(input logic [W-1:0] va, vb, input logic ar, sb, ch, fi,
                        input logic [2:0] f);
      @(posedge clk);
      #1;
      a = va; b = vb; arith = ar; sub = sb; chain = ch; fin = fi; fn = f;
      #3;
   endtask

   task automatic check(input string req, input logic [W-1:0] ar, er,
                        input logic af, ef, az);
      logic ez;
      ez = (er == '0);
      checks++;
      if (ar !== er || af !== ef || az !== ez) begin
         errors++;
         $display("FAIL %s: got res=%h flag=%b zero=%b expected res=%h flag=%b zero=%b",
                  req, ar, af, az, er, ef, ez);
      end
   endtask

   function automatic logic [W-1:0] rop(input logic [2:0] f, input logic [W-1:0] x, y);
      case (f)
         3'd0: return x & y;
         3'd1: return x | y;
         3'd2: return x ^ y;
         3'd3: return x & ~y;
         3'd4: return ~(x & y);
         3'd5: return ~(x | y);
         3'd6: return ~(x ^ y);
         default: return x | ~y;
      endcase
   endfunction

   function automatic logic [W-1:0] pat(input int i, input int s);
      return W'((i * 16'h3A71 + s * 16'h1F0D) ^ (i << 5));
   endfunction

   task automatic t_idle();
      drive('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
      check("R9 idle", res, '0, fo, 1'b0, zo);
   endtask

   task automatic t_add();
      for (int i = 0; i < 6; i++) begin
         int s;
         logic [W-1:0] x, y;
         x = pat(i, 1); y = pat(i, 2);
         s = int'(x) + int'(y);
         drive(x, y, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5);
         check("R1 add", res, W'(s), fo, s > 16'hFFFF, zo);
      end
      drive(16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
      check("R1 add wrap R9", res, '0, fo, 1'b1, zo);
   endtask

   task automatic t_adc();
      drive(16'hFFFF, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0);
      check("R4 adc carry", res, '0, fo, 1'b1, zo);
      drive(16'h1234, 16'h0100, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3);
      check("R4 adc R10", res, 16'h1335, fo, 1'b0, zo);
      drive(16'h1234, 16'h0100, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0);
      check("R4 adc no carry", res, 16'h1334, fo, 1'b0, zo);
   endtask

   task automatic t_sub();
      for (int i = 0; i < 6; i++) begin
         logic [W-1:0] x, y;
         x = pat(i, 3); y = pat(i, 4);
         drive(x, y, 1'b1, 1'b1, 1'b0, 1'b1, 3'd7);
         check("R2 sub", res, W'(x - y), fo, x < y, zo);
      end
      drive(16'h0005, 16'h0005, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0);
      check("R2 sub equal R9", res, '0, fo, 1'b0, zo);
      drive(16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0);
      check("R2 sub underflow", res, 16'hFFFF, fo, 1'b1, zo);
   endtask

   task automatic t_sbb();
      drive(16'h0007, 16'h0007, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0);
      check("R3 sbb borrow in", res, 16'hFFFF, fo, 1'b1, zo);
      drive(16'h0007, 16'h0003, 1'b1, 1'b1, 1'b1, 1'b1, 3'd4);
      check("R3 sbb R10", res, 16'h0003, fo, 1'b0, zo);
      drive(16'h0007, 16'h0007, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0);
      check("R3 sbb no borrow", res, '0, fo, 1'b0, zo);
   endtask

   task automatic t_logic();
      for (int f = 0; f < 8; f++) begin
         for (int i = 0; i < 2; i++) begin
            logic [W-1:0] x, y;
            x = (i == 0) ? 16'hF0F0 : pat(f, 5);
            y = (i == 0) ? 16'hCC33 : pat(f, 6);
            drive(x, y, 1'b0, 1'b0, 1'b0, 1'b0, 3'(f));
            check(f < 4 ? "R5 logic" : "R6 logic", res, rop(3'(f), x, y), fo, 1'b0, zo);
         end
      end
   endtask

   task automatic t_logic_ignores();
      for (int f = 0; f < 8; f++) begin
         drive(16'hA5C3, 16'h3C96, 1'b0, 1'b1, 1'b1, 1'b1, 3'(f));
         check("R8 logic ignores arith ctl", res, rop(3'(f), 16'hA5C3, 16'h3C96), fo, 1'b0, zo);
      end
      drive(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 3'd2);
      check("R8 R9 xor zero", res, '0, fo, 1'b0, zo);
   endtask

   task automatic t_reduced();
      for (int f = 0; f < 8; f++) begin
         drive(16'h96F0, 16'h5A3C, 1'b0, 1'b0, 1'b0, 1'b0, 3'(f));
         check("R7 reduced", res_r, rop(3'(f % 4), 16'h96F0, 16'h5A3C), fo_r, 1'b0, zo_r);
      end
   endtask

   initial begin
      a = '0; b = '0; arith = 1'b0; sub = 1'b0; chain = 1'b0; fin = 1'b0; fn = '0;
      t_idle();
      t_add();
      t_adc();
      t_sub();
      t_sbb();
      t_logic();
      t_logic_ignores();
      t_reduced();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule